// File: doc/BRIEF.md
# GPIO Port Register File with Set/Clear Aliases

This block is the software-visible register file of a 32-pin general-purpose I/O port. A simple word-wide read/write bus reaches an output-level register and a direction register. Each can be written three ways: replaced, ORed with the data, or cleared under a mask. There is also one configuration word per pin and a read-only register that holds the sampled pin inputs. The stored output levels, direction bits and configuration words are presented on flat output ports. A separate pin-resolution block consumes them. Pad behaviour and event detection belong to that block, not to this one.

A pin's direction is visible in two places: as bit n of the direction register and as bit 0 of pin n's configuration word. A write through either view is seen at once through the other. Internally the direction bit is held only once, and each configuration word is assembled from that bit and the stored upper 31 bits. Reads are registered and return data one cycle after the request. Only full-word writes (all four byte strobes set) are accepted.

Top module: `gpio_regfile`

## Requirements
- R1: While rst_n is low at a clock edge, the output-level and direction registers become 0, the sampled-input register becomes 0, every configuration word becomes 0x00000002, and bus_rdata becomes 0.
- R2: An accepted write to offset 0x504 replaces the output-level register with bus_wdata.
- R3: An accepted write to offset 0x508 ORs bus_wdata into the output-level register.
- R4: An accepted write to offset 0x50C clears each output-level bit whose bus_wdata bit is 1 and leaves the other bits unchanged.
- R5: Offsets 0x514, 0x518 and 0x51C replace, OR into and mask-clear the direction register in the same way.
- R6: A read of 0x504, 0x508 or 0x50C returns the output-level register. A read of 0x514, 0x518 or 0x51C returns the direction register. bus_rdata updates on the edge that samples bus_rd, and it shows the value held before any write accepted on that same edge.
- R7: After any write to a direction offset, bit 0 of the configuration word for every pin n equals direction bit n.
- R8: An accepted write to offset 0x700 + 4*n (n = 0..31) stores the whole word as pin n's configuration and sets direction bit n to bus_wdata bit 0. The other pins' configuration and direction bits do not change. A read of that offset returns the stored word.
- R9: A read of 0x510 returns pin_in as it was sampled on the clock edge before the read edge. Writes to 0x510 change no register.
- R10: Reads of any other offset, including offsets whose two low bits are not 0, return 0. Writes to such offsets change no register.
- R11: A write with bus_be not equal to 4'b1111 is ignored entirely.
- R12: cfg_flat carries pin n's configuration word in bits [32*n+31 : 32*n]. out_level and dir_mask carry bit n for pin n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write request for this cycle |
| bus_rd | input | 1 | Read request for this cycle |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes; a write needs all four set |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pin levels from the pin-resolution block |
| out_level | output | 32 | Stored output level per pin |
| dir_mask | output | 32 | Stored direction per pin (1 = output) |
| cfg_flat | output | 1024 | All configuration words, pin n at bits 32n+31:32n |

## Verification
A read and a write can be accepted on the same edge. The bench provokes this by raising bus_rd and bus_wr together on the output-level offset and on a configuration offset. It expects bus_rdata to carry the value held before the edge, while the ports already show the new value. A direction write through a configuration offset and a readback through the direction view can also land in back-to-back cycles. The bench sweeps every pin that way and compares against a model of both views.

// File: rtl/gpio_rf_pkg.sv
// Package: shared offsets and encodings of the GPIO register file.
// Assumes byte offsets compared as 32-bit unsigned integers.
package gpio_rf_pkg;

    localparam int OFS_OUT    = 'h504;
    localparam int OFS_OUTSET = 'h508;
    localparam int OFS_OUTCLR = 'h50C;
    localparam int OFS_IN     = 'h510;
    localparam int OFS_DIR    = 'h514;
    localparam int OFS_DIRSET = 'h518;
    localparam int OFS_DIRCLR = 'h51C;
    localparam int OFS_CFG    = 'h700;

    // Register targeted by one access
    typedef enum logic [3:0] {
        RK_NONE,
        RK_OUT,
        RK_OUTSET,
        RK_OUTCLR,
        RK_IN,
        RK_DIR,
        RK_DIRSET,
        RK_DIRCLR,
        RK_CFG
    } reg_kind_e;

    // Update applied to an aliased register in one cycle
    typedef enum logic [2:0] {
        AOP_HOLD,
        AOP_LOAD,
        AOP_SET,
        AOP_CLR,
        AOP_BIT
    } alias_op_e;

endpackage

// File: rtl/gpio_rf_decode.sv
// Address decoder: maps a byte offset to the register kind and, for the
// configuration window, to the pin index. Offsets whose two low bits are
// not zero decode to RK_NONE. Assumes NPINS >= 2.
module gpio_rf_decode
    import gpio_rf_pkg::*;
#(
    parameter int AW    = 12,
    parameter int NPINS = 32,
    localparam int IDXW = $clog2(NPINS)
) (
    input  logic [AW-1:0]   addr,
    output reg_kind_e       kind,
    output logic [IDXW-1:0] idx
);

    logic [31:0]   a32;
    logic [AW-1:0] cfg_off;

    assign a32     = 32'(addr);
    assign cfg_off = addr - AW'(OFS_CFG);
    assign idx     = IDXW'(cfg_off >> 2);

    // Classify the offset into one register kind
    always_comb begin
        kind = RK_NONE;
        if (addr[1:0] != 2'b00) begin
            kind = RK_NONE;
        end else if (a32 == 32'(OFS_OUT)) begin
            kind = RK_OUT;
        end else if (a32 == 32'(OFS_OUTSET)) begin
            kind = RK_OUTSET;
        end else if (a32 == 32'(OFS_OUTCLR)) begin
            kind = RK_OUTCLR;
        end else if (a32 == 32'(OFS_IN)) begin
            kind = RK_IN;
        end else if (a32 == 32'(OFS_DIR)) begin
            kind = RK_DIR;
        end else if (a32 == 32'(OFS_DIRSET)) begin
            kind = RK_DIRSET;
        end else if (a32 == 32'(OFS_DIRCLR)) begin
            kind = RK_DIRCLR;
        end else if (a32 >= 32'(OFS_CFG) && a32 < 32'(OFS_CFG + 4 * NPINS)) begin
            kind = RK_CFG;
        end
    end

endmodule

// File: rtl/gpio_rf_alias_reg.sv
// Aliased register: one storage word updated by replace, OR, mask-clear
// or single-bit load. At most one operation is applied per cycle.
module gpio_rf_alias_reg
    import gpio_rf_pkg::*;
#(
    parameter int             W    = 32,
    parameter logic [W-1:0]   RSTV = '0,
    localparam int            IDXW = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  alias_op_e       op,
    input  logic [W-1:0]    wdata,
    input  logic [IDXW-1:0] bit_sel,
    input  logic            bit_val,
    output logic [W-1:0]    q
);

    // Apply the selected update to the stored word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RSTV;
        end else begin
            case (op)
                AOP_LOAD: q <= wdata;
                AOP_SET:  q <= q | wdata;
                AOP_CLR:  q <= q & ~wdata;
                AOP_BIT:  q[bit_sel] <= bit_val;
                default:  q <= q;
            endcase
        end
    end

endmodule

// File: rtl/gpio_rf_cfg_bank.sv
// Per-pin configuration bank: stores bits [DW-1:1] of each pin's word.
// Bit 0 of each word is the pin's direction bit, supplied from outside,
// so the two views of direction cannot disagree.
module gpio_rf_cfg_bank #(
    parameter int            NPINS = 32,
    parameter int            DW    = 32,
    parameter logic [DW-1:0] RSTV  = 32'h0000_0002,
    localparam int           IDXW  = $clog2(NPINS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [IDXW-1:0]    wr_idx,
    input  logic [DW-1:1]      wdata_hi,
    input  logic [NPINS-1:0]   dir_bits,
    input  logic [IDXW-1:0]    rd_idx,
    output logic [DW-1:0]      rd_word,
    output logic [NPINS*DW-1:0] cfg_flat
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [DW-1:1] hi_q;

        // Store the upper configuration bits of this pin on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q <= RSTV[DW-1:1];
            end else if (wr_stb && wr_idx == IDXW'(p)) begin
                hi_q <= wdata_hi;
            end
        end

        assign cfg_flat[p*DW +: DW] = {hi_q, dir_bits[p]};
    end

    assign rd_word = cfg_flat[rd_idx*DW +: DW];

endmodule

// File: rtl/gpio_regfile.sv
// GPIO port register file. Decodes word accesses, updates the output-level
// and direction registers through their aliases, holds per-pin
// configuration and samples pin inputs. Reads are registered: bus_rdata
// follows the edge that samples bus_rd and shows pre-write values.
// Assumes 2 <= NPINS <= 32 and bus_addr wide enough for offset 0x77C.
module gpio_regfile
    import gpio_rf_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [AW-1:0]       bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic [3:0]          bus_be,
    output logic [31:0]         bus_rdata,
    input  logic [NPINS-1:0]    pin_in,
    output logic [NPINS-1:0]    out_level,
    output logic [NPINS-1:0]    dir_mask,
    output logic [NPINS*32-1:0] cfg_flat
);

    localparam int DW   = 32;
    localparam int IDXW = $clog2(NPINS);
    localparam logic [DW-1:0] CFG_RSTV = 32'h0000_0002;

    reg_kind_e       kind;
    logic [IDXW-1:0] idx;
    logic            wr_ok;
    alias_op_e       out_op;
    alias_op_e       dir_op;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] in_q;
    logic [DW-1:0]   cfg_word;
    logic [DW-1:0]   rd_mux;

    gpio_rf_decode #(.AW(AW), .NPINS(NPINS)) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .idx  (idx)
    );

    assign wr_ok = bus_wr && (bus_be == 4'b1111);

    // Choose the update applied to the output-level register
    always_comb begin
        out_op = AOP_HOLD;
        if (wr_ok) begin
            case (kind)
                RK_OUT:    out_op = AOP_LOAD;
                RK_OUTSET: out_op = AOP_SET;
                RK_OUTCLR: out_op = AOP_CLR;
                default:   out_op = AOP_HOLD;
            endcase
        end
    end

    // Choose the update applied to the direction register
    always_comb begin
        dir_op = AOP_HOLD;
        if (wr_ok) begin
            case (kind)
                RK_DIR:    dir_op = AOP_LOAD;
                RK_DIRSET: dir_op = AOP_SET;
                RK_DIRCLR: dir_op = AOP_CLR;
                RK_CFG:    dir_op = AOP_BIT;
                default:   dir_op = AOP_HOLD;
            endcase
        end
    end

    gpio_rf_alias_reg #(.W(NPINS), .RSTV('0)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (out_op),
        .wdata   (NPINS'(bus_wdata)),
        .bit_sel ('0),
        .bit_val (1'b0),
        .q       (out_q)
    );

    gpio_rf_alias_reg #(.W(NPINS), .RSTV('0)) u_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (dir_op),
        .wdata   (NPINS'(bus_wdata)),
        .bit_sel (idx),
        .bit_val (bus_wdata[0]),
        .q       (dir_q)
    );

    gpio_rf_cfg_bank #(.NPINS(NPINS), .DW(DW), .RSTV(CFG_RSTV)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_ok && kind == RK_CFG),
        .wr_idx   (idx),
        .wdata_hi (bus_wdata[DW-1:1]),
        .dir_bits (dir_q),
        .rd_idx   (idx),
        .rd_word  (cfg_word),
        .cfg_flat (cfg_flat)
    );

    // Sample the pin levels every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q <= '0;
        end else begin
            in_q <= pin_in;
        end
    end

    // Select the word returned for the decoded offset
    always_comb begin
        case (kind)
            RK_OUT, RK_OUTSET, RK_OUTCLR: rd_mux = 32'(out_q);
            RK_IN:                        rd_mux = 32'(in_q);
            RK_DIR, RK_DIRSET, RK_DIRCLR: rd_mux = 32'(dir_q);
            RK_CFG:                       rd_mux = cfg_word;
            default:                      rd_mux = '0;
        endcase
    end

    // Capture read data on a read request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    assign out_level = out_q;
    assign dir_mask  = dir_q;

    // ---------------- assertions ----------------
    // Track the last accepted configuration write for R8
    logic            chk_cfg_vld;
    logic [IDXW-1:0] chk_cfg_idx;
    logic            chk_cfg_bit;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_cfg_vld <= 1'b0;
            chk_cfg_idx <= '0;
            chk_cfg_bit <= 1'b0;
        end else begin
            chk_cfg_vld <= wr_ok && kind == RK_CFG;
            chk_cfg_idx <= idx;
            chk_cfg_bit <= bus_wdata[0];
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (out_level == '0 && dir_mask == '0 && bus_rdata == '0
                    && cfg_flat[DW-1:0] == CFG_RSTV));

    a_r2_out_replace: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_be == 4'b1111 && bus_addr == AW'(OFS_OUT))
        |=> out_level == $past(NPINS'(bus_wdata)));

    a_r3_out_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_be == 4'b1111 && bus_addr == AW'(OFS_OUTSET))
        |=> out_level == ($past(out_level) | $past(NPINS'(bus_wdata))));

    a_r4_out_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_be == 4'b1111 && bus_addr == AW'(OFS_OUTCLR))
        |=> out_level == ($past(out_level) & ~$past(NPINS'(bus_wdata))));

    a_r5_dir_replace: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_be == 4'b1111 && bus_addr == AW'(OFS_DIR))
        |=> dir_mask == $past(NPINS'(bus_wdata)));

    a_r8_cfg_sets_dir: assert property (@(posedge clk) disable iff (!rst_n)
        chk_cfg_vld |-> dir_mask[chk_cfg_idx] == chk_cfg_bit);

    a_r9_in_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFS_IN))
        |=> ($stable(out_level) && $stable(dir_mask) && $stable(cfg_flat)));

    a_r11_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_be != 4'b1111)
        |=> ($stable(out_level) && $stable(dir_mask) && $stable(cfg_flat)));

endmodule

// File: tb/sim_gpio_regfile.sv
// Bench for gpio_regfile: sweeps every alias and every configuration
// register against an arithmetic model of both direction views.
module sim_gpio_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            bus_wr, bus_rd;
    logic [11:0]     bus_addr;
    logic [31:0]     bus_wdata;
    logic [3:0]      bus_be;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pin_in;
    logic [NP-1:0]   out_level, dir_mask;
    logic [NP*32-1:0] cfg_flat;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] m_out, m_dir;
    logic [31:0] m_cfg [NP];

    gpio_regfile u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .out_level(out_level),
        .dir_mask(dir_mask), .cfg_flat(cfg_flat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'h0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // Model: a write to a direction offset refreshes every cfg bit 0
    function automatic void sync_cfg_from_dir();
        for (int p = 0; p < NP; p++) m_cfg[p][0] = m_dir[p];
    endfunction

    task automatic check_ports(input string req);
        chk({req, " out_level"}, out_level, m_out);
        chk({req, " dir_mask"}, dir_mask, m_dir);
        for (int p = 0; p < NP; p++) chk({req, " cfg_flat"}, cfg_flat[p*32 +: 32], m_cfg[p]);
    endtask

    // Watchdog: a hung run is counted as a failure
    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd, pat, old;
        logic [11:0] unm [7];
        bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; bus_be = '0;
        pin_in = '0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_out = '0; m_dir = '0;
        for (int p = 0; p < NP; p++) m_cfg[p] = 32'h2;

        // R1 reset state at ports and through reads
        chk("R1 rdata", bus_rdata, 32'h0);
        check_ports("R1");
        bus_read(12'h510, rd); chk("R1 IN", rd, 32'h0);
        bus_read(12'h704, rd); chk("R1 cfg1", rd, 32'h2);

        // R2 R3 R4 R6: sweep output-level aliases, read back via each alias
        for (int k = 0; k < 12; k++) begin
            pat = 32'h9E37_79B9 * (k + 1);
            case (k % 3)
                0: begin bus_write(12'h504, pat, 4'hF); m_out = pat; end
                1: begin bus_write(12'h508, pat, 4'hF); m_out = m_out | pat; end
                default: begin bus_write(12'h50C, pat, 4'hF); m_out = m_out & ~pat; end
            endcase
            chk((k%3==0) ? "R2 out" : (k%3==1) ? "R3 out" : "R4 out", out_level, m_out);
            bus_read(12'h504 + 12'(4 * ((k + 1) % 3)), rd);
            chk("R6 out alias read", rd, m_out);
        end

        // R5 R6 R7: sweep direction aliases, cfg bit 0 follows
        for (int k = 0; k < 12; k++) begin
            pat = 32'h85EB_CA6B * (k + 3) ^ (32'h1 << k);
            case (k % 3)
                0: begin bus_write(12'h514, pat, 4'hF); m_dir = pat; end
                1: begin bus_write(12'h518, pat, 4'hF); m_dir = m_dir | pat; end
                default: begin bus_write(12'h51C, pat, 4'hF); m_dir = m_dir & ~pat; end
            endcase
            sync_cfg_from_dir();
            check_ports("R5 R7 R12");
            bus_read(12'h514 + 12'(4 * ((k + 2) % 3)), rd);
            chk("R6 dir alias read", rd, m_dir);
        end

        // R8: every configuration word, read back through cfg and DIR views
        for (int p = 0; p < NP; p++) begin
            pat = (32'h0101_0101 * p) ^ 32'hC3A5_0000 ^ 32'(p & 1) ^ 32'(p << 4);
            bus_write(12'h700 + 12'(4 * p), pat, 4'hF);
            m_cfg[p] = pat; m_dir[p] = pat[0];
            bus_read(12'h514, rd); chk("R8 dir from cfg", rd, m_dir);
            bus_read(12'h700 + 12'(4 * p), rd); chk("R8 cfg read", rd, m_cfg[p]);
        end
        check_ports("R8 R12");

        // R9: sampled input and write to IN ignored
        for (int k = 0; k < 4; k++) begin
            pin_in = 32'hF0E1_D2C3 ^ (32'h1111_1111 * k);
            bus_read(12'h510, rd); chk("R9 IN read", rd, pin_in);
        end
        @(negedge clk);
        old = pin_in;
        bus_rd = 1'b1; bus_addr = 12'h510; pin_in = ~old;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R9 IN previous edge", bus_rdata, old);
        bus_write(12'h510, 32'hFFFF_FFFF, 4'hF);
        check_ports("R9 write ignored");
        bus_read(12'h510, rd); chk("R9 IN after write", rd, ~old);

        // R10: unmapped and misaligned offsets
        unm = '{12'h000, 12'h500, 12'h520, 12'h6FC, 12'h780, 12'h706, 12'hFFC};
        for (int k = 0; k < 7; k++) begin
            bus_write(unm[k], 32'hFFFF_FFFF, 4'hF);
            check_ports("R10 write");
            bus_read(unm[k], rd); chk("R10 read", rd, 32'h0);
        end

        // R11: partial strobes ignored on OUT, DIR and cfg
        for (int b = 0; b < 15; b++) begin
            bus_write(12'h504, ~m_out, 4'(b));
            bus_write(12'h514, ~m_dir, 4'(b));
            bus_write(12'h708, ~m_cfg[2], 4'(b));
            check_ports("R11");
        end

        // R6: read and write on the same edge return the old value
        @(negedge clk);
        old = m_out;
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 12'h504; bus_wdata = 32'h1234_5678; bus_be = 4'hF;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_be = 4'h0;
        m_out = 32'h1234_5678;
        chk("R6 RAW rdata old", bus_rdata, old);
        chk("R2 RAW out new", out_level, m_out);
        @(negedge clk);
        old = m_cfg[5];
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 12'h714; bus_wdata = ~old; bus_be = 4'hF;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_be = 4'h0;
        m_cfg[5] = ~old; m_dir[5] = ~old[0];
        chk("R8 RAW rdata old", bus_rdata, old);
        check_ports("R8 RAW");

        // R1: reset again after activity
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_out = '0; m_dir = '0;
        for (int p = 0; p < NP; p++) m_cfg[p] = 32'h2;
        check_ports("R1 re-reset");
        chk("R1 rdata re-reset", bus_rdata, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule